// File: doc/BRIEF.md
# Rotor Lock Protection Timer

This block guards a motor drive against a stalled or runaway rotor. When the drive is commanded to run, it times how long the speed loop stays out of lock. If the unlocked stretch lasts longer than a programmed number of timer ticks, it sets a latched shutdown that turns off the low-side switches of the output stage. The tick period comes from a prescaler on the system clock, which stands in for an analog timing capacitor. The shutdown stays set until the drive is commanded to stop or the block is reset. The loss of the reference clock needs no extra logic: without a reference the loop never locks, so the motor turns for one timeout and is then shut off.

The same prescaler also produces the power-up logic reset. After the power-on reset is released, the logic reset output stays high for a fixed number of ticks, and fault timing does not start until it falls. A deceleration flag, raised while the reference frequency is being lowered, keeps the timer from counting. A configuration input can disable fault detection altogether, while the power-up reset pulse is still produced.

Top module: `rotor_guard`

## Requirements
- R1: `logic_rst` is 1 while `rst` is 1, and stays 1 for exactly BOOT_TICKS*TICK_DIV clock edges after the first edge with `rst`=0. It then goes to 0 and stays 0 until the next `rst`.
- R2: After reset, `shutdown` is 0.
- R3: With `run_req`=1, `locked`=0, `decel`=0, `fault_en`=1 and `logic_rst`=0 held continuously, `shutdown` is still 0 after (TRIP_TICKS-1)*TICK_DIV edges and is 1 after TRIP_TICKS*TICK_DIV+1 edges. A missing reference clock, which never gives lock, therefore ends in `shutdown`=1.
- R4: A single cycle with `locked`=1 restarts the unlocked interval from zero.
- R5: Once set, `shutdown` stays 1 while `run_req`=1, whatever the values of `locked`, `decel` and `fault_en`.
- R6: `run_req`=0 at a clock edge leaves `shutdown`=0 after that edge.
- R7: `decel`=1 restarts the unlocked interval, and while `decel` is held at 1 no shutdown occurs.
- R8: With `fault_en`=0 no shutdown occurs, and the power-up pulse on `logic_rst` is still produced as in R1.
- R9: While `logic_rst`=1, `shutdown` is 0 and no unlocked time is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| run_req | input | 1 | 1 = drive commanded to run, 0 = stop (also clears the fault) |
| locked | input | 1 | 1 = speed loop in lock |
| decel | input | 1 | 1 = deceleration after a reference frequency change |
| fault_en | input | 1 | 1 = stall fault detection enabled |
| shutdown | output | 1 | Latched stall fault; low-side drive off while 1 |
| logic_rst | output | 1 | Power-up reset for the drive logic |

## Verification
The bench goes after the exact edges where the trip can fall. An off-by-one tick count would trip one prescaler period early or late, so the bench samples just below and just above the window. A one-cycle lock pulse or decel pulse must restart the interval. A design that only pauses the count would trip too soon after the pulse. The bench also checks that a tripped fault survives lock, decel and a disable. A design that cleared the fault on lock would re-enable a stalled drive. It checks that stop clears the fault in one edge, and that fault timing stays idle during the boot pulse. Long random stretches of start, stop, lock and decel are compared cycle by cycle against a reference model built into the bench.

// File: rtl/rotor_guard_pkg.sv
package rotor_guard_pkg;

    localparam int unsigned DEF_TICK_DIV   = 1000;
    localparam int unsigned DEF_TRIP_TICKS = 8000;
    localparam int unsigned DEF_BOOT_TICKS = 4;

    typedef enum logic [1:0] {
        GUARD_IDLE    = 2'd0,
        GUARD_WATCH   = 2'd1,
        GUARD_TRIPPED = 2'd2
    } guard_state_e;

    typedef struct packed {
        logic run;
        logic unlocked;
        logic decel;
        logic enabled;
        logic booting;
    } guard_cond_t;

    function automatic logic guard_armed(input guard_cond_t c);
        return c.run && c.unlocked && !c.decel && c.enabled && !c.booting;
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rotor_guard_prescaler.sv
module rotor_guard_prescaler
    import rotor_guard_pkg::*;
#(
    parameter int unsigned TICK_DIV = DEF_TICK_DIV
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned DIV_W = width_of(TICK_DIV);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    assign tick = (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/rotor_guard_boot.sv
module rotor_guard_boot
    import rotor_guard_pkg::*;
#(
    parameter int unsigned BOOT_TICKS = DEF_BOOT_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic booting
);
    localparam int unsigned BOOT_W = width_of(BOOT_TICKS);
    localparam logic [BOOT_W-1:0] BOOT_LAST = BOOT_W'(BOOT_TICKS - 1);

    logic [BOOT_W-1:0] boot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            booting <= 1'b1;
            boot_q  <= '0;
        end else if (booting && tick) begin
            if (boot_q == BOOT_LAST) begin
                booting <= 1'b0;
                boot_q  <= '0;
            end else begin
                boot_q <= boot_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rotor_guard_stall.sv
module rotor_guard_stall
    import rotor_guard_pkg::*;
#(
    parameter int unsigned TRIP_TICKS = DEF_TRIP_TICKS
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  guard_cond_t cond,
    output logic        tripped
);
    localparam int unsigned TRIP_W = width_of(TRIP_TICKS);
    localparam logic [TRIP_W-1:0] TRIP_LAST = TRIP_W'(TRIP_TICKS - 1);

    guard_state_e      state_q;
    logic [TRIP_W-1:0] ticks_q;
    logic              armed;

    assign armed   = guard_armed(cond);
    assign tripped = (state_q == GUARD_TRIPPED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GUARD_IDLE;
            ticks_q <= '0;
        end else if (!cond.run) begin
            state_q <= GUARD_IDLE;
            ticks_q <= '0;
        end else if (state_q == GUARD_TRIPPED) begin
            state_q <= GUARD_TRIPPED;
        end else if (armed) begin
            state_q <= GUARD_WATCH;
            if (tick) begin
                if (ticks_q == TRIP_LAST) begin
                    state_q <= GUARD_TRIPPED;
                    ticks_q <= '0;
                end else begin
                    ticks_q <= ticks_q + 1'b1;
                end
            end
        end else begin
            state_q <= GUARD_IDLE;
            ticks_q <= '0;
        end
    end
endmodule

// File: rtl/rotor_guard.sv
module rotor_guard
    import rotor_guard_pkg::*;
#(
    parameter int unsigned TICK_DIV   = DEF_TICK_DIV,
    parameter int unsigned TRIP_TICKS = DEF_TRIP_TICKS,
    parameter int unsigned BOOT_TICKS = DEF_BOOT_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic run_req,
    input  logic locked,
    input  logic decel,
    input  logic fault_en,
    output logic shutdown,
    output logic logic_rst
);
    logic        tick;
    logic        booting;
    guard_cond_t cond;

    assign cond.run      = run_req;
    assign cond.unlocked = !locked;
    assign cond.decel    = decel;
    assign cond.enabled  = fault_en;
    assign cond.booting  = booting;

    rotor_guard_prescaler #(.TICK_DIV(TICK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rotor_guard_boot #(.BOOT_TICKS(BOOT_TICKS)) u_boot (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .booting (booting)
    );

    rotor_guard_stall #(.TRIP_TICKS(TRIP_TICKS)) u_stall (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cond    (cond),
        .tripped (shutdown)
    );

    assign logic_rst = booting;
endmodule

// File: rtl/rotor_guard_chk.sv
module rotor_guard_chk #(
    parameter int unsigned TICK_DIV   = 4,
    parameter int unsigned TRIP_TICKS = 4
) (
    input logic clk,
    input logic rst,
    input logic run_req,
    input logic locked,
    input logic decel,
    input logic fault_en,
    input logic shutdown,
    input logic logic_rst
);
    localparam int unsigned MIN_EDGES = (TRIP_TICKS - 1) * TICK_DIV + 1;

    logic [31:0] run_len;
    logic        window_live;

    assign window_live = run_req && !locked && !decel && fault_en && !logic_rst && !shutdown;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (window_live) begin
            if (run_len != 32'hFFFF_FFFF) run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    assert_boot_stays_low_R1: assert property (@(posedge clk) disable iff (rst)
        !logic_rst |=> !logic_rst);

    assert_trip_not_early_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> (run_len >= MIN_EDGES));

    assert_trip_needs_unlock_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> $past(!locked));

    assert_fault_latched_R5: assert property (@(posedge clk) disable iff (rst)
        (shutdown && run_req) |=> shutdown);

    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !run_req |=> !shutdown);

    assert_no_trip_in_decel_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> $past(!decel));

    assert_no_trip_disabled_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> $past(fault_en));

    assert_quiet_in_boot_R9: assert property (@(posedge clk) disable iff (rst)
        logic_rst |-> !shutdown);
endmodule

bind rotor_guard rotor_guard_chk #(.TICK_DIV(TICK_DIV), .TRIP_TICKS(TRIP_TICKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run_req   (run_req),
    .locked    (locked),
    .decel     (decel),
    .fault_en  (fault_en),
    .shutdown  (shutdown),
    .logic_rst (logic_rst)
);

// File: tb/rotor_guard_tb_top.sv
module rotor_guard_tb_top;
    localparam int unsigned P  = 4;
    localparam int unsigned TO = 10;
    localparam int unsigned RT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_req = 1'b0;
    logic locked = 1'b0;
    logic decel = 1'b0;
    logic fault_en = 1'b1;
    logic shutdown;
    logic logic_rst;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit compare_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rotor_guard #(.TICK_DIV(P), .TRIP_TICKS(TO), .BOOT_TICKS(RT)) dut_i (
        .clk(clk), .rst(rst), .run_req(run_req), .locked(locked),
        .decel(decel), .fault_en(fault_en), .shutdown(shutdown), .logic_rst(logic_rst)
    );

    // Reference model built from the requirements
    int  m_phase = 0;
    int  m_boot_ticks = 0;
    int  m_unlock_ticks = 0;
    bit  m_boot = 1'b1;
    bit  m_sd = 1'b0;

    always @(posedge clk) begin
        bit t;
        if (rst) begin
            m_phase = 0; m_boot = 1'b1; m_boot_ticks = 0;
            m_unlock_ticks = 0; m_sd = 1'b0;
        end else begin
            t = (m_phase == P - 1);
            m_phase = t ? 0 : m_phase + 1;
            if (!run_req) begin
                m_sd = 1'b0; m_unlock_ticks = 0;
            end else if (!m_sd) begin
                if (!locked && !decel && fault_en && !m_boot) begin
                    if (t) m_unlock_ticks++;
                    if (m_unlock_ticks == TO) begin
                        m_sd = 1'b1; m_unlock_ticks = 0;
                    end
                end else begin
                    m_unlock_ticks = 0;
                end
            end
            if (m_boot && t) begin
                m_boot_ticks++;
                if (m_boot_ticks == RT) m_boot = 1'b0;
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_in(input logic r, input logic l, input logic d, input logic e);
        run_req = r; locked = l; decel = d; fault_en = e;
    endtask

    task automatic do_reset(input string req);
        rst = 1'b1;
        wait_n(3);
        chk(logic_rst, 1'b1, req);
        rst = 1'b0;
        wait_n(RT * P - 1);
        chk(logic_rst, 1'b1, req);
        wait_n(1);
        chk(logic_rst, 1'b0, req);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (compare_on) begin
            chk(shutdown, m_sd, "R3/R5/R6 random shutdown");
            chk(logic_rst, m_boot, "R1 random logic_rst");
        end
    end

    initial begin
        void'($urandom(32'd2024));
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        wait_n(3);
        chk(shutdown, 1'b0, "R2 reset");
        chk(logic_rst, 1'b1, "R1 during rst");
        // R9: run requested during boot, no counting
        do_reset("R1 boot pulse");
        chk(shutdown, 1'b0, "R9 no trip during boot");
        set_in(1'b0, 1'b0, 1'b0, 1'b1);
        wait_n(2);

        // R3 trip window
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        wait_n((TO - 1) * P);
        chk(shutdown, 1'b0, "R3 not early");
        wait_n(P + 1);
        chk(shutdown, 1'b1, "R3 trip");

        // R5 latched
        set_in(1'b1, 1'b1, 1'b1, 1'b0);
        wait_n(20);
        chk(shutdown, 1'b1, "R5 latched");

        // R6 stop clears
        run_req = 1'b0;
        wait_n(1);
        chk(shutdown, 1'b0, "R6 stop clears");

        // R4 lock pulse restarts
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        wait_n((TO - 1) * P);
        locked = 1'b1; wait_n(1); locked = 1'b0;
        wait_n((TO - 1) * P);
        chk(shutdown, 1'b0, "R4 lock restarts");
        wait_n(P + 2);
        chk(shutdown, 1'b1, "R4 trip after restart");
        run_req = 1'b0; wait_n(1);

        // R7 decel pulse and hold
        set_in(1'b1, 1'b0, 1'b0, 1'b1);
        wait_n((TO - 1) * P);
        decel = 1'b1; wait_n(1); decel = 1'b0;
        wait_n((TO - 1) * P);
        chk(shutdown, 1'b0, "R7 decel restarts");
        decel = 1'b1;
        wait_n(3 * TO * P);
        chk(shutdown, 1'b0, "R7 decel held");
        decel = 1'b0; run_req = 1'b0; wait_n(1);

        // R8 disabled
        set_in(1'b1, 1'b0, 1'b0, 1'b0);
        wait_n(3 * TO * P);
        chk(shutdown, 1'b0, "R8 disabled no trip");
        do_reset("R8 boot pulse with fault_en=0");
        wait_n(3 * TO * P);
        chk(shutdown, 1'b0, "R8 disabled after boot");

        // Random phase against model
        set_in(1'b0, 1'b0, 1'b0, 1'b1);
        rst = 1'b1; wait_n(2); rst = 1'b0;
        compare_on = 1'b1;
        for (int i = 0; i < 600; i++) begin
            int k;
            k = $urandom_range(0, 99);
            run_req  = (k < 85);
            locked   = ($urandom_range(0, 99) < 25);
            decel    = ($urandom_range(0, 99) < 8);
            fault_en = ($urandom_range(0, 99) < 90);
            if ($urandom_range(0, 199) == 0) rst = 1'b1;
            wait_n($urandom_range(1, 3 * TO * P / 2));
            rst = 1'b0;
        end
        compare_on = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule